// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This combinational unit executes the second byte of a two-byte prefixed opcode in an 8-bit processor core. It also executes the four one-byte accumulator rotates. For each operation it takes the opcode, one 8-bit operand and the incoming flags. It returns the result byte, the new flags, a mask that shows which flags the instruction updates, and a write-back enable.

The low three opcode bits pick the operand. The unit decodes them into a register index and a memory-operand indication. An outer sequencer uses these to fetch the operand and to insert read-modify-write cycles when the operand lives in memory at the HL address. The register file and the memory cycles are outside this unit.

The flags are packed as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C. The `flg_out` output always gives the final flag values: any flag whose mask bit is 0 comes through from `flg_in` unchanged.

Top module: `rsb_unit`

## Requirements
- R1: With `pfx`=1, opcode bits 7:3 select the rotates: 00000 rotate left circular (C and bit 0 take old bit 7), 00001 rotate right circular (C and bit 7 take old bit 0), 00010 rotate left through carry (bit 0 takes C in, C takes old bit 7), 00011 rotate right through carry (bit 7 takes C in, C takes old bit 0).
- R2: With `pfx`=1, opcode bits 7:3 select the shifts and the swap: 00100 shift left with a 0 filled in (C takes old bit 7), 00101 arithmetic shift right (C takes old bit 0), 00110 swap the two nibbles (C cleared), 00111 logical shift right with a 0 filled in (C takes old bit 0).
- R3: Every prefixed rotate, shift or swap sets Z when the result is zero and clears N and H. It drives `flg_mask`=4'b1111 and `wr_en`=1.
- R4: The arithmetic shift right keeps bit 7 of the result equal to the old bit 7.
- R5: With `pfx`=1 and opcode bits 7:6 = 01, the unit tests the bit whose number is opcode bits 5:3. Z is set when that bit is 0, N is cleared, H is set and C keeps its incoming value. The outputs are `flg_mask`=4'b1110, `wr_en`=0 and `res`=operand.
- R6: With `pfx`=1, opcode bits 7:6 = 10 clear the bit numbered by opcode bits 5:3 and 11 set it. No other bit changes. The outputs are `flg_out`=`flg_in`, `flg_mask`=0 and `wr_en`=1.
- R7: With `pfx`=0, opcodes 0x07, 0x0F, 0x17 and 0x1F give the same result, C, N, H, mask and write enable as prefixed opcodes 0x07, 0x0F, 0x17 and 0x1F, but Z is always 0.
- R8: `reg_sel` equals opcode bits 2:0 when `pfx`=1, where 0 to 7 mean B, C, D, E, H, L, memory at HL and A. When `pfx`=0, `reg_sel` is 7 (A). `mem_op` is 1 exactly when `pfx`=1 and opcode bits 2:0 = 110.
- R9: With `pfx`=0 and any other opcode, the unit does nothing: `res`=operand, `flg_out`=`flg_in`, `flg_mask`=0 and `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pfx | input | 1 | 1: opcode is the byte after the prefix; 0: unprefixed opcode |
| opc | input | 8 | Opcode byte |
| opnd | input | 8 | Operand value |
| flg_in | input | 4 | Incoming flags {Z,N,H,C} |
| res | output | 8 | Result byte |
| flg_out | output | 4 | Final flags {Z,N,H,C} |
| flg_mask | output | 4 | Flags the instruction updates |
| wr_en | output | 1 | Result must be written back |
| reg_sel | output | 3 | Operand register index |
| mem_op | output | 1 | Operand is memory at HL |

## Verification
The hardest case to reach is a rotate whose result is zero. For the through-carry forms, this only happens when the carry-in and the operand line up: for example, operand 0x80 rotated left with C=0 gives zero and sets C. The stimulus therefore runs all 256 prefixed opcodes over the fixed operands 0x00, 0x01, 0x80 and 0xFF and over random operands, each with both carry-in values. It also runs the four short rotates with the same zero-producing operands, to check that they keep Z at 0 where the prefixed forms set it.

// File: rtl/rsb_unit.sv
module rsb_unit (
  input  logic       pfx,
  input  logic [7:0] opc,
  input  logic [7:0] opnd,
  input  logic [3:0] flg_in,
  output logic [7:0] res,
  output logic [3:0] flg_out,
  output logic [3:0] flg_mask,
  output logic       wr_en,
  output logic [2:0] reg_sel,
  output logic       mem_op
);
  logic [1:0] grp;
  logic [2:0] sel;
  logic       short_rot;
  logic       act;
  logic [7:0] bmask;
  logic [7:0] sh_res;
  logic       sh_c;

  assign grp       = opc[7:6];
  assign sel       = opc[5:3];
  assign short_rot = !pfx && opc[7:5] == 3'b000 && opc[2:0] == 3'b111;
  assign act       = pfx || short_rot;
  assign bmask     = 8'h01 << sel;
  assign reg_sel   = pfx ? opc[2:0] : 3'd7;
  assign mem_op    = pfx && opc[2:0] == 3'b110;

  always_comb begin
    case (sel)
      3'd0: begin sh_res = {opnd[6:0], opnd[7]};   sh_c = opnd[7]; end
      3'd1: begin sh_res = {opnd[0], opnd[7:1]};   sh_c = opnd[0]; end
      3'd2: begin sh_res = {opnd[6:0], flg_in[0]}; sh_c = opnd[7]; end
      3'd3: begin sh_res = {flg_in[0], opnd[7:1]}; sh_c = opnd[0]; end
      3'd4: begin sh_res = {opnd[6:0], 1'b0};      sh_c = opnd[7]; end
      3'd5: begin sh_res = {opnd[7], opnd[7:1]};   sh_c = opnd[0]; end
      3'd6: begin sh_res = {opnd[3:0], opnd[7:4]}; sh_c = 1'b0;    end
      default: begin sh_res = {1'b0, opnd[7:1]};   sh_c = opnd[0]; end
    endcase
  end

  always_comb begin
    res      = opnd;
    flg_out  = flg_in;
    flg_mask = 4'h0;
    wr_en    = 1'b0;
    if (act) begin
      case (short_rot ? 2'b00 : grp)
        2'b00: begin
          res      = sh_res;
          flg_out  = {!short_rot && sh_res == 8'h00, 1'b0, 1'b0, sh_c};
          flg_mask = 4'hF;
          wr_en    = 1'b1;
        end
        2'b01: begin
          flg_out  = {~opnd[sel], 1'b0, 1'b1, flg_in[0]};
          flg_mask = 4'hE;
        end
        2'b10: begin
          res   = opnd & ~bmask;
          wr_en = 1'b1;
        end
        default: begin
          res   = opnd | bmask;
          wr_en = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk (
  input logic       pfx,
  input logic [7:0] opc,
  input logic [7:0] opnd,
  input logic [3:0] flg_in,
  input logic [7:0] res,
  input logic [3:0] flg_out,
  input logic [3:0] flg_mask,
  input logic       wr_en,
  input logic [2:0] reg_sel,
  input logic       mem_op
);
  logic known;
  logic is_short;
  assign known    = !$isunknown({pfx, opc, opnd, flg_in});
  assign is_short = !pfx && (opc == 8'h07 || opc == 8'h0F || opc == 8'h17 || opc == 8'h1F);

  always_comb begin
    if (known) begin
      // R3
      shift_flags_chk: assert (!(pfx && opc[7:6] == 2'b00) ||
        (flg_out[2:1] == 2'b00 && flg_out[3] == (res == 8'h00) && flg_mask == 4'hF && wr_en))
        else $error("shift_flags_chk");
      // R4
      sra_sign_chk: assert (!(pfx && opc[7:3] == 5'b00101) || res[7] == opnd[7])
        else $error("sra_sign_chk");
      // R5
      bit_test_chk: assert (!(pfx && opc[7:6] == 2'b01) ||
        (!wr_en && res == opnd && flg_out == {~opnd[opc[5:3]], 1'b0, 1'b1, flg_in[0]}))
        else $error("bit_test_chk");
      // R6
      bit_mod_chk: assert (!(pfx && opc[7]) ||
        (flg_out == flg_in && flg_mask == 4'h0 && wr_en && $countones(res ^ opnd) <= 1))
        else $error("bit_mod_chk");
      // R7
      short_z_chk: assert (!is_short || (flg_out[3] == 1'b0 && wr_en))
        else $error("short_z_chk");
      // R8
      mem_sel_chk: assert (mem_op == (pfx && reg_sel == 3'd6))
        else $error("mem_sel_chk");
      // R9
      idle_chk: assert (pfx || is_short || (!wr_en && flg_mask == 4'h0 && res == opnd && flg_out == flg_in))
        else $error("idle_chk");
    end
  end
endmodule

bind rsb_unit rsb_unit_chk u_chk (.*);

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;
  typedef struct packed {
    logic [7:0] r;
    logic [3:0] f;
    logic [3:0] m;
    logic       w;
    logic [2:0] i;
    logic       mo;
  } obs_t;
  typedef struct { obs_t e; string tag; } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic pfx = 0;
  logic [7:0] opc = 0, opnd = 0;
  logic [3:0] flg_in = 0;
  logic [7:0] res;
  logic [3:0] flg_out, flg_mask;
  logic wr_en, mem_op;
  logic [2:0] reg_sel;
  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  always #4 clk = ~clk;

  rsb_unit u_rsb_unit (.pfx(pfx), .opc(opc), .opnd(opnd), .flg_in(flg_in), .res(res),
    .flg_out(flg_out), .flg_mask(flg_mask), .wr_en(wr_en), .reg_sel(reg_sel), .mem_op(mem_op));

  function automatic obs_t model(bit p, logic [7:0] o, logic [7:0] a, logic [3:0] f);
    obs_t e;
    int k;
    bit c, z;
    logic [7:0] r;
    e = '{r: a, f: f, m: 4'h0, w: 1'b0, i: p ? o[2:0] : 3'd7, mo: p && o[2:0] == 3'd6};
    if (p || o == 8'h07 || o == 8'h0F || o == 8'h17 || o == 8'h1F) begin
      k = o[5:3];
      if (o[7:6] == 2'b00) begin
        c = 0;
        case (k)  // R1 R2 R4
          0: begin r = (a << 1) | (a >> 7); c = a[7]; end
          1: begin r = (a >> 1) | (a << 7); c = a[0]; end
          2: begin r = (a << 1) | 8'(f[0]); c = a[7]; end
          3: begin r = (a >> 1) | (8'(f[0]) << 7); c = a[0]; end
          4: begin r = a << 1; c = a[7]; end
          5: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
          6: begin r = (a << 4) | (a >> 4); c = 0; end
          default: begin r = a >> 1; c = a[0]; end
        endcase
        z = p ? (r == 0) : 1'b0;  // R3 R7
        e.r = r; e.f = {z, 2'b00, c}; e.m = 4'hF; e.w = 1;
      end else if (o[7:6] == 2'b01) begin  // R5
        e.f = {((a >> k) & 8'h01) == 0, 1'b0, 1'b1, f[0]}; e.m = 4'hE;
      end else begin  // R6
        e.r = o[6] ? (a | (8'h01 << k)) : (a & ~(8'h01 << k)); e.w = 1;
      end
    end
    return e;
  endfunction

  function automatic string tag_of(bit p, logic [7:0] o);
    if (!p) return (o == 8'h07 || o == 8'h0F || o == 8'h17 || o == 8'h1F) ? "R7" : "R9";
    if (o[7:6] == 2'b01) return "R5";
    if (o[7]) return "R6";
    if (o[7:3] == 5'b00101) return "R4";
    return o[5] ? "R2/R3/R8" : "R1/R3/R8";
  endfunction

  task automatic drive(bit p, logic [7:0] o, logic [7:0] a, logic [3:0] f);
    item_t it;
    @(negedge clk);
    pfx = p; opc = o; opnd = a; flg_in = f;
    it.e = model(p, o, a, f);
    it.tag = tag_of(p, o);
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      obs_t got;
      it = q.pop_front();
      got = '{r: res, f: flg_out, m: flg_mask, w: wr_en, i: reg_sel, mo: mem_op};
      checks++;
      if (got !== it.e) begin
        fails++;
        $display("FAIL %s pfx=%0b op=%h opnd=%h fin=%h: got r=%h f=%h m=%h w=%0b i=%0d mo=%0b exp r=%h f=%h m=%h w=%0b i=%0d mo=%0b",
          it.tag, pfx, opc, opnd, flg_in, got.r, got.f, got.m, got.w, got.i, got.mo,
          it.e.r, it.e.f, it.e.m, it.e.w, it.e.i, it.e.mo);
      end
    end
  end

  initial begin
    logic [7:0] pats[4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(0, 8'h00, 8'h00, 4'h0);  // R9 reset state
    for (int op = 0; op < 256; op++)
      for (int cin = 0; cin < 2; cin++) begin
        for (int j = 0; j < 4; j++) drive(1, 8'(op), pats[j], {3'($urandom), 1'(cin)});
        drive(1, 8'(op), 8'($urandom), {3'($urandom), 1'(cin)});
        drive(1, 8'(op), 8'($urandom), {3'($urandom), 1'(cin)});
      end
    // R7 short rotates, including zero results
    for (int s = 0; s < 4; s++)
      for (int cin = 0; cin < 2; cin++) begin
        for (int j = 0; j < 4; j++) drive(0, 8'(8'h07 + 8 * s), pats[j], {3'b101, 1'(cin)});
        drive(0, 8'(8'h07 + 8 * s), 8'($urandom), {3'($urandom), 1'(cin)});
      end
    // R9 other unprefixed opcodes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] o;
      o = 8'($urandom);
      if (o == 8'h07 || o == 8'h0F || o == 8'h17 || o == 8'h1F) o = 8'h27;
      drive(0, o, 8'($urandom), 4'($urandom));
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(posedge clk); n++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule